// File: doc/BRIEF.md
# Transmit Host-Write Byte Packer

The block sits between a host register port and a byte-wide transmit queue. The host first writes a packet size, then a setup word holding a byte-order flag, a leading trim, a trailing trim and a countdown of the data writes still to come. It then writes 32-bit data words one at a time. The block works out which byte lanes of each word are real payload, puts them in transmit order and sends them out one byte per cycle over a valid/ready handshake. It marks the final byte of a word written when the countdown is zero as the end of the packet.

The leading trim is used only once. The trailing trim stays set until the host writes the setup word again. When the countdown is zero, a non-zero remainder of the packet size (size modulo 4) takes precedence over the trailing trim. While the block still holds bytes from a word, it deasserts its data-ready output so that no word is lost when the output stalls.

Top module: `txq_byte_packer`

## Requirements
- R1: After reset, out_valid and out_last are 0 and dat_ready is 1. The countdown, both trims, the packet size and the byte-order flag are all 0, so the first word after reset emits all four bytes, least significant first, with out_last on the fourth byte.
- R2: cfg_msb_first=1 emits bits 31:24 first and bits 7:0 last. cfg_msb_first=0 emits bits 7:0 first and bits 31:24 last.
- R3: When the countdown is non-zero, a data word drops cfg_start_off bytes from the side that is emitted first and emits the remaining bytes.
- R4: The leading trim clears to 0 after the first word it was applied to, so the next word is emitted in full.
- R5: Each accepted data word decrements a non-zero countdown by one. At zero the countdown holds until the next setup write. A setup write in the same cycle as a data word wins.
- R6: When the countdown is zero and the size remainder is 0, a data word drops cfg_end_off bytes from the side that is emitted last. The leading trim is not applied.
- R7: The trailing trim is not self-clearing. Every later word written at countdown zero is trimmed the same way and ends a packet.
- R8: When the countdown is zero and size_val[1:0] is non-zero, exactly that many bytes are emitted from the first-emitted side, overriding the trailing trim.
- R9: While bytes of a word are pending, dat_ready is 0 and further data writes are not taken. While out_ready is 0, out_valid, out_byte and out_last hold steady.
- R10: out_last is 1 only on the final emitted byte of a word written when the countdown was zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Setup write strobe |
| cfg_msb_first | input | 1 | Byte order: 1 = most significant byte first |
| cfg_start_off | input | 2 | Leading trim in bytes |
| cfg_end_off | input | 2 | Trailing trim in bytes |
| cfg_count | input | 14 | Data writes in the buffer minus one |
| size_we | input | 1 | Packet size write strobe |
| size_val | input | 16 | Packet size in bytes |
| dat_valid | input | 1 | Data write request |
| dat_word | input | 32 | Data word |
| dat_ready | output | 1 | Data write accepted when high |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output byte |
| out_last | output | 1 | Last byte of the packet |
| out_ready | input | 1 | Downstream ready |

## Verification
The lane selection is driven with single-word cases that cross both byte orders with each trim source: leading trim at a non-zero countdown, trailing trim at zero, size remainder at zero, and a leading trim that is ignored because the countdown is already zero. These cases show whether bytes are dropped from the correct side and whether the correct source sets the byte count. A three-word packet followed by extra words checks that the countdown steps down and then holds, that the trailing trim stays in force, and that a later size write overrides it. A leading trim of three followed by a full word confirms that the trim clears itself. A stalled output with a competing data write checks that the pending bytes hold steady and are not corrupted.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int TXQ_DATA_W = 32;
    localparam int TXQ_BYTE_W = 8;
    localparam int TXQ_CNT_W  = 14;
    localparam int TXQ_SIZE_W = 16;

    typedef enum logic {
        ORD_LSB_FIRST = 1'b0,
        ORD_MSB_FIRST = 1'b1
    } byte_order_e;
endpackage

// File: rtl/txq_setup_regs.sv
module txq_setup_regs
    import txq_pkg::*;
#(
    parameter int CNT_W  = TXQ_CNT_W,
    parameter int SIZE_W = TXQ_SIZE_W,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  byte_order_e       cfg_order,
    input  logic [IDX_W-1:0]  cfg_soff,
    input  logic [IDX_W-1:0]  cfg_eoff,
    input  logic [CNT_W-1:0]  cfg_cnt,
    input  logic              size_we,
    input  logic [SIZE_W-1:0] size_val,
    input  logic              take,
    output byte_order_e       order_q,
    output logic [IDX_W-1:0]  soff_q,
    output logic [IDX_W-1:0]  eoff_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [SIZE_W-1:0] size_q
);
    typedef struct packed {
        byte_order_e       order;
        logic [IDX_W-1:0]  soff;
        logic [IDX_W-1:0]  eoff;
        logic [CNT_W-1:0]  cnt;
        logic [SIZE_W-1:0] size;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (size_we) begin
            r_d.size = size_val;
        end
        if (take && (r_q.cnt != '0)) begin
            r_d.cnt  = r_q.cnt - CNT_W'(1);
            r_d.soff = '0;
        end
        if (cfg_we) begin
            r_d.order = cfg_order;
            r_d.soff  = cfg_soff;
            r_d.eoff  = cfg_eoff;
            r_d.cnt   = cfg_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{order: ORD_LSB_FIRST, soff: '0, eoff: '0, cnt: '0, size: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign order_q = r_q.order;
    assign soff_q  = r_q.soff;
    assign eoff_q  = r_q.eoff;
    assign cnt_q   = r_q.cnt;
    assign size_q  = r_q.size;
endmodule

// File: rtl/txq_lane_planner.sv
module txq_lane_planner
    import txq_pkg::*;
#(
    parameter int BYTE_W = TXQ_BYTE_W,
    parameter int LANES  = 4,
    parameter int IDX_W  = 2
) (
    input  logic [LANES*BYTE_W-1:0]        word,
    input  byte_order_e                    order,
    input  logic [IDX_W-1:0]               soff,
    input  logic [IDX_W-1:0]               eoff,
    input  logic                           cnt_zero,
    input  logic [IDX_W-1:0]               rem,
    output logic [LANES-1:0][BYTE_W-1:0]   lanes,
    output logic [IDX_W-1:0]               first_idx,
    output logic [IDX_W-1:0]               last_idx,
    output logic                           eop
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(LANES - 1);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lanes[i] = (order == ORD_MSB_FIRST)
                        ? word[(LANES-1-i)*BYTE_W +: BYTE_W]
                        : word[i*BYTE_W +: BYTE_W];
    end

    always_comb begin
        first_idx = '0;
        last_idx  = TOP_IDX;
        eop       = 1'b0;
        if (!cnt_zero) begin
            first_idx = soff;
        end else begin
            eop = 1'b1;
            if (rem != '0) begin
                last_idx = rem - IDX_W'(1);
            end else begin
                last_idx = TOP_IDX - eoff;
            end
        end
    end
endmodule

// File: rtl/txq_byte_shifter.sv
module txq_byte_shifter
    import txq_pkg::*;
#(
    parameter int BYTE_W = TXQ_BYTE_W,
    parameter int LANES  = 4,
    parameter int IDX_W  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_valid,
    output logic                         load_ready,
    input  logic [LANES-1:0][BYTE_W-1:0] lanes,
    input  logic [IDX_W-1:0]             first_idx,
    input  logic [IDX_W-1:0]             last_idx,
    input  logic                         eop,
    output logic                         out_valid,
    output logic [BYTE_W-1:0]            out_byte,
    output logic                         out_last,
    input  logic                         out_ready
);
    typedef struct packed {
        logic                         busy;
        logic [IDX_W-1:0]             pos;
        logic [IDX_W-1:0]             stop;
        logic                         eop;
        logic [LANES-1:0][BYTE_W-1:0] hold;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (load_valid) begin
                s_d.busy = 1'b1;
                s_d.pos  = first_idx;
                s_d.stop = last_idx;
                s_d.eop  = eop;
                s_d.hold = lanes;
            end
        end else if (out_ready) begin
            if (s_q.pos == s_q.stop) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.pos = s_q.pos + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign load_ready = !s_q.busy;
    assign out_valid  = s_q.busy;
    assign out_byte   = s_q.hold[s_q.pos];
    assign out_last   = s_q.busy && s_q.eop && (s_q.pos == s_q.stop);
endmodule

// File: rtl/txq_byte_packer.sv
module txq_byte_packer
    import txq_pkg::*;
#(
    parameter int DATA_W = TXQ_DATA_W,
    parameter int BYTE_W = TXQ_BYTE_W,
    parameter int CNT_W  = TXQ_CNT_W,
    parameter int SIZE_W = TXQ_SIZE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_msb_first,
    input  logic [1:0]        cfg_start_off,
    input  logic [1:0]        cfg_end_off,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              size_we,
    input  logic [SIZE_W-1:0] size_val,
    input  logic              dat_valid,
    input  logic [DATA_W-1:0] dat_word,
    output logic              dat_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_last,
    input  logic              out_ready
);
    localparam int LANES = DATA_W / BYTE_W;
    localparam int IDX_W = $clog2(LANES);

    byte_order_e                  order_q;
    logic [IDX_W-1:0]             soff_q, eoff_q;
    logic [CNT_W-1:0]             cnt_q;
    logic [SIZE_W-1:0]            size_q;
    logic                         take;
    logic [LANES-1:0][BYTE_W-1:0] lanes;
    logic [IDX_W-1:0]             first_idx, last_idx;
    logic                         eop;

    assign take = dat_valid && dat_ready;

    txq_setup_regs #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_order (byte_order_e'(cfg_msb_first)),
        .cfg_soff  (IDX_W'(cfg_start_off)),
        .cfg_eoff  (IDX_W'(cfg_end_off)),
        .cfg_cnt   (cfg_count),
        .size_we   (size_we),
        .size_val  (size_val),
        .take      (take),
        .order_q   (order_q),
        .soff_q    (soff_q),
        .eoff_q    (eoff_q),
        .cnt_q     (cnt_q),
        .size_q    (size_q)
    );

    txq_lane_planner #(.BYTE_W(BYTE_W), .LANES(LANES), .IDX_W(IDX_W)) u_plan (
        .word      (dat_word),
        .order     (order_q),
        .soff      (soff_q),
        .eoff      (eoff_q),
        .cnt_zero  (cnt_q == '0),
        .rem       (size_q[IDX_W-1:0]),
        .lanes     (lanes),
        .first_idx (first_idx),
        .last_idx  (last_idx),
        .eop       (eop)
    );

    txq_byte_shifter #(.BYTE_W(BYTE_W), .LANES(LANES), .IDX_W(IDX_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (dat_valid),
        .load_ready (dat_ready),
        .lanes      (lanes),
        .first_idx  (first_idx),
        .last_idx   (last_idx),
        .eop        (eop),
        .out_valid  (out_valid),
        .out_byte   (out_byte),
        .out_last   (out_last),
        .out_ready  (out_ready)
    );
endmodule

// File: rtl/txq_packer_chk.sv
module txq_packer_chk #(
    parameter int CNT_W  = 14,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              dat_valid,
    input logic              dat_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_byte,
    input logic              out_last,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [IDX_W-1:0]  soff_q
);
    // R9
    busy_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !dat_ready);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

    // R10
    last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && dat_valid && dat_ready && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R5
    count_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && cnt_q == '0) |=> (cnt_q == '0));

    // R4
    start_trim_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && dat_valid && dat_ready && cnt_q != '0) |=> (soff_q == '0));
endmodule

bind txq_byte_packer txq_packer_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .dat_valid (dat_valid),
    .dat_ready (dat_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_last  (out_last),
    .cnt_q     (cnt_q),
    .soff_q    (soff_q)
);

// File: tb/tb_txq_byte_packer.sv
module tb_txq_byte_packer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    localparam int VW = 103;

    // big | soff | eoff | count | size | word | nbytes | packed bytes (first emitted most significant) | eop
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 2'd0, 14'd0, 16'd0,  32'h44332211, 3'd4, 32'h11223344, 1'b1},
        {1'b1, 2'd0, 2'd0, 14'd0, 16'd0,  32'h44332211, 3'd4, 32'h44332211, 1'b1},
        {1'b0, 2'd0, 2'd1, 14'd0, 16'd0,  32'h44332211, 3'd3, 32'h00112233, 1'b1},
        {1'b1, 2'd0, 2'd3, 14'd0, 16'd0,  32'h44332211, 3'd1, 32'h00000044, 1'b1},
        {1'b0, 2'd2, 2'd0, 14'd5, 16'd0,  32'h44332211, 3'd2, 32'h00003344, 1'b0},
        {1'b1, 2'd1, 2'd0, 14'd1, 16'd0,  32'h44332211, 3'd3, 32'h00332211, 1'b0},
        {1'b0, 2'd0, 2'd2, 14'd0, 16'd13, 32'h44332211, 3'd1, 32'h00000011, 1'b1},
        {1'b1, 2'd0, 2'd1, 14'd0, 16'd6,  32'h44332211, 3'd2, 32'h00004433, 1'b1},
        {1'b0, 2'd3, 2'd3, 14'd0, 16'd0,  32'h44332211, 3'd1, 32'h00000011, 1'b1}
    };
    localparam string VREQ [NVEC] = '{"R2", "R2", "R6", "R6", "R3", "R3", "R8", "R8", "R6"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_msb_first = 1'b0;
    logic [1:0]  cfg_start_off = '0, cfg_end_off = '0;
    logic [13:0] cfg_count = '0;
    logic        size_we = 1'b0;
    logic [15:0] size_val = '0;
    logic        dat_valid = 1'b0;
    logic [31:0] dat_word = '0;
    logic        dat_ready, out_valid, out_last;
    logic [7:0]  out_byte;
    logic        out_ready = 1'b1;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txq_byte_packer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_msb_first(cfg_msb_first),
        .cfg_start_off(cfg_start_off), .cfg_end_off(cfg_end_off), .cfg_count(cfg_count),
        .size_we(size_we), .size_val(size_val), .dat_valid(dat_valid), .dat_word(dat_word),
        .dat_ready(dat_ready), .out_valid(out_valid), .out_byte(out_byte),
        .out_last(out_last), .out_ready(out_ready)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_size(input logic [15:0] sz);
        @(negedge clk);
        size_we = 1'b1; size_val = sz;
        @(negedge clk);
        size_we = 1'b0;
    endtask

    task automatic wr_setup(input logic big, input logic [1:0] so, input logic [1:0] eo, input logic [13:0] cnt);
        @(negedge clk);
        cfg_we = 1'b1; cfg_msb_first = big; cfg_start_off = so; cfg_end_off = eo; cfg_count = cnt;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        while (!dat_ready) @(negedge clk);
        dat_valid = 1'b1; dat_word = w;
        @(negedge clk);
        dat_valid = 1'b0;
    endtask

    task automatic collect_check(input string req, input int exp_n, input logic [31:0] exp_pack, input logic exp_eop);
        int n = 0;
        int nlast = 0;
        logic [31:0] pk = '0;
        logic eop = 1'b0;
        for (int c = 0; c < 12; c++) begin
            if (out_valid) begin
                pk = (pk << 8) | 32'(out_byte);
                n++;
                if (out_last) nlast++;
                eop = out_last;
            end else if (n > 0) begin
                break;
            end
            @(negedge clk);
        end
        check(req, "byte count", 32'(n), 32'(exp_n));
        check(req, "bytes", pk, exp_pack);
        check("R10", "last on final byte", 32'(eop), 32'(exp_eop));
        check("R10", "last count", 32'(nlast), 32'(exp_eop));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        check("R1", "out_valid", 32'(out_valid), 32'd0);
        check("R1", "out_last", 32'(out_last), 32'd0);
        check("R1", "dat_ready", 32'(dat_ready), 32'd0 + 32'd1);
        rst_n = 1'b1;
        push(32'h44332211);
        collect_check("R1", 4, 32'h11223344, 1'b1);

        for (int v = 0; v < NVEC; v++) begin
            logic [VW-1:0] e;
            e = VEC[v];
            wr_size(e[83:68]);
            wr_setup(e[102], e[101:100], e[99:98], e[97:84]);
            push(e[67:36]);
            collect_check(VREQ[v], int'(e[35:33]), e[32:1], e[0]);
        end

        // R5 R6 R7 R8: three-word packet, then words past the end
        wr_size(16'd8);
        wr_setup(1'b0, 2'd1, 2'd2, 14'd2);
        push(32'hA3A2A1A0);
        collect_check("R3", 3, 32'h00A1A2A3, 1'b0);
        push(32'hB3B2B1B0);
        collect_check("R5", 4, 32'hB0B1B2B3, 1'b0);
        push(32'hC3C2C1C0);
        collect_check("R6", 2, 32'h0000C0C1, 1'b1);
        push(32'hD3D2D1D0);
        collect_check("R7", 2, 32'h0000D0D1, 1'b1);
        wr_size(16'd7);
        push(32'hE3E2E1E0);
        collect_check("R8", 3, 32'h00E0E1E2, 1'b1);

        // R4 leading trim self-clears
        wr_size(16'd0);
        wr_setup(1'b1, 2'd3, 2'd0, 14'd2);
        push(32'h11223344);
        collect_check("R4", 1, 32'h00000044, 1'b0);
        push(32'h55667788);
        collect_check("R4", 4, 32'h55667788, 1'b0);

        // R9 stall with a competing data write
        wr_setup(1'b0, 2'd0, 2'd0, 14'd0);
        out_ready = 1'b0;
        push(32'hDDCCBBAA);
        dat_valid = 1'b1; dat_word = 32'h99999999;
        for (int k = 0; k < 4; k++) begin
            check("R9", "stalled valid", 32'(out_valid), 32'd1);
            check("R9", "stalled byte", 32'(out_byte), 32'h000000AA);
            check("R9", "dat_ready low", 32'(dat_ready), 32'd0);
            @(negedge clk);
        end
        dat_valid = 1'b0;
        out_ready = 1'b1;
        collect_check("R9", 4, 32'hAABBCCDD, 1'b1);
        check("R9", "no extra word", 32'(out_valid), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule